// File: doc/BRIEF.md
# Linked-Descriptor Byte-Stream DMA Engine

This block moves a data transfer between system memory and a byte-wide card data port by following a chain of descriptors held in memory. Each descriptor is four 32-bit words: a status word, a buffer size, a buffer address and the address of the following descriptor. After a start pulse, the engine fetches the descriptor at the programmed base address and moves its share of the transfer, one memory word and up to four card bytes at a time. It then writes the status word back with the ownership bit cleared. It either ends or moves on to the next descriptor.

The memory side is a word request interface: the request is held until an acknowledge, and there are byte enables for writes. The card side has a transmit byte stream and a receive byte stream, each with a valid/ready handshake. The receive valid also serves as the card data-ready indication. When the walk ends, the engine pulses `done`. It also presents the completion flags that the surrounding interrupt logic merges into its raw and DMA status registers. Those flags hold their value until the next accepted start.

Top module: `sdma_chain_engine`

## Requirements
- R1: A `start` pulse is accepted only when `dma_en` is 1, `byte_count` is nonzero and `block_size` is nonzero. When `dir_tx` is 0 (card-to-memory), `card_rx_valid` must also be 1 in that same cycle. A start that is not accepted has no effect: `busy` stays 0 and no memory request or card handshake is made.
- R2: Descriptor word k (0 = status, 1 = size, 2 = buffer address, 3 = next address) is read from byte address base + 4k. The direction is the value of `dir_tx` captured at the accepted start: 1 means memory-to-card and 0 means card-to-memory.
- R3: A size word of 0 is treated as MAX_DESC_BYTES. A size word larger than MAX_DESC_BYTES is clamped to MAX_DESC_BYTES.
- R4: Each descriptor moves the smaller of its effective size and the remaining byte count. Bits 1:0 of the buffer address are ignored. Byte i of the buffer sits in lane i mod 4, at bits 8(i mod 4)+7 down to 8(i mod 4), of the word at aligned address + 4(i div 4).
- R5: In memory-to-card mode, the buffer bytes leave on `card_tx_data` in ascending order, one per cycle in which both `card_tx_valid` and `card_tx_ready` are high. No byte is lost or repeated under any stall pattern.
- R6: In card-to-memory mode, each byte accepted while both `card_rx_valid` and `card_rx_ready` are high is written to the next buffer byte. Memory writes enable only the lanes that carry moved bytes, so every other memory byte keeps its value.
- R7: After a descriptor's data has moved, its status word is written back to word 0 with bit 31 cleared and all other bits unchanged.
- R8: After each descriptor, `bytes_left` drops by the bytes that descriptor moved. The walk ends after a descriptor whose status bit 2 (last) is set, or when `bytes_left` reaches 0. Otherwise the walk continues at the next-descriptor address. A descriptor that is never reached keeps its status word.
- R9: At the end of the walk, `done` is high for exactly one cycle. In that same cycle `raw_flags` becomes 0x00010008 (bits 3 and 16). `dma_flags` becomes 0x101 for memory-to-card or 0x102 for card-to-memory. Both flag outputs are cleared at the next accepted start.
- R10: `mem_req` stays high with a stable address and write flag until `mem_ack`. `card_tx_valid` stays high with stable data until `card_tx_ready`.
- R11: After reset, `busy`, `done`, `mem_req`, `card_tx_valid` and `card_rx_ready` are 0, and `raw_flags`, `dma_flags` and `bytes_left` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse |
| dma_en | input | 1 | DMA enable from global control |
| dir_tx | input | 1 | 1 = memory to card, 0 = card to memory |
| byte_count | input | WORD_W | Total bytes to move |
| block_size | input | WORD_W | Block size; only tested for nonzero |
| desc_base | input | WORD_W | Byte address of the first descriptor |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 = write request |
| mem_addr | output | WORD_W | Word-aligned byte address |
| mem_wdata | output | WORD_W | Write data |
| mem_be | output | WORD_W/BYTE_W | Write byte enables |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | WORD_W | Read data, valid with acknowledge |
| card_tx_valid | output | 1 | Byte offered to the card |
| card_tx_data | output | BYTE_W | Byte to the card |
| card_tx_ready | input | 1 | Card accepts a byte |
| card_rx_valid | input | 1 | Card byte ready |
| card_rx_data | input | BYTE_W | Byte from the card |
| card_rx_ready | output | 1 | Engine takes a card byte |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| raw_flags | output | WORD_W | Completion bits for the raw interrupt status |
| dma_flags | output | WORD_W | Completion bits for the DMA status |
| bytes_left | output | WORD_W | Remaining byte count |

## Verification
The assertions assume that the memory side returns `mem_ack` only while `mem_req` is high, with read data valid in that same cycle. They also assume that the card side moves a byte only in a cycle where both valid and ready are high. The bench memory acknowledges one cycle after a request at the earliest and never acknowledges twice in a row, so every request completes exactly once. In the stalled runs, acknowledge and both card handshakes are held back on fixed cycle patterns. Descriptors and buffers are placed so that they never overlap, so the write-backs cannot disturb data still waiting to move. Card-to-memory runs wait for `card_rx_valid` before pulsing `start`, so the start is accepted under R1.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  // Status-word bit positions that the engine decodes or rewrites.
  localparam int unsigned DESC_OWN_BIT  = 31;
  localparam int unsigned DESC_LAST_BIT = 2;

  // Completion bit positions handed to the interrupt logic.
  localparam int unsigned RAW_XFER_DONE = 3;
  localparam int unsigned RAW_DMA_EVENT = 16;
  localparam int unsigned DMA_TX_DONE   = 0;
  localparam int unsigned DMA_RX_DONE   = 1;
  localparam int unsigned DMA_SUMMARY   = 8;

  typedef enum logic [3:0] {
    WK_IDLE,
    WK_STAT,
    WK_SIZE,
    WK_BUF,
    WK_NEXT,
    WK_SEG,
    WK_MRD,
    WK_LANE,
    WK_MWR,
    WK_WB,
    WK_FIN
  } wk_state_e;

endpackage

// File: rtl/sdma_chunk_calc.sv
module sdma_chunk_calc #(
  parameter int WORD_W         = 32,
  parameter int MAX_DESC_BYTES = 8192
) (
  input  logic [WORD_W-1:0] size_raw,
  input  logic [WORD_W-1:0] remaining,
  output logic [WORD_W-1:0] chunk
);

  localparam logic [WORD_W-1:0] MAX_V = WORD_W'(MAX_DESC_BYTES);

  logic [WORD_W-1:0] eff_size;

  always_comb begin
    eff_size = ((size_raw == '0) || (size_raw > MAX_V)) ? MAX_V : size_raw;
    chunk    = (eff_size < remaining) ? eff_size : remaining;
  end

endmodule

// File: rtl/sdma_byte_lane.sv
module sdma_byte_lane #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES = WORD_W / BYTE_W,
  localparam int IDX_W = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              dir_tx,
  input  logic [WORD_W-1:0] word_in,
  input  logic [IDX_W-1:0]  nbytes,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic [WORD_W-1:0] word_out,
  output logic              done
);

  logic              active;
  logic              dir_q;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  cnt;
  logic [WORD_W-1:0] buf_q;
  logic              step;

  assign tx_valid = active & dir_q;
  assign rx_ready = active & ~dir_q;
  assign tx_data  = buf_q[int'(idx)*BYTE_W +: BYTE_W];
  assign word_out = buf_q;
  assign step     = dir_q ? tx_ready : rx_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      dir_q  <= 1'b0;
      idx    <= '0;
      cnt    <= '0;
      buf_q  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        active <= 1'b1;
        dir_q  <= dir_tx;
        idx    <= '0;
        cnt    <= nbytes;
        buf_q  <= word_in;
      end else if (active && step) begin
        if (!dir_q) begin
          buf_q[int'(idx)*BYTE_W +: BYTE_W] <= rx_data;
        end
        idx <= idx + 1'b1;
        if (idx + 1'b1 == cnt) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sdma_walker.sv
module sdma_walker
  import sdma_pkg::*;
#(
  parameter int WORD_W         = 32,
  parameter int BYTE_W         = 8,
  parameter int MAX_DESC_BYTES = 8192,
  localparam int WORD_BYTES    = WORD_W / BYTE_W,
  localparam int ALIGN_W       = $clog2(WORD_BYTES),
  localparam int IDX_W         = $clog2(WORD_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  dma_en,
  input  logic                  dir_tx,
  input  logic [WORD_W-1:0]     byte_count,
  input  logic [WORD_W-1:0]     block_size,
  input  logic [WORD_W-1:0]     desc_base,
  input  logic                  card_ready,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [WORD_W-1:0]     mem_addr,
  output logic [WORD_W-1:0]     mem_wdata,
  output logic [WORD_BYTES-1:0] mem_be,
  input  logic                  mem_ack,
  input  logic [WORD_W-1:0]     mem_rdata,
  output logic                  lane_go,
  output logic                  lane_dir,
  output logic [WORD_W-1:0]     lane_word,
  output logic [IDX_W-1:0]      lane_nbytes,
  input  logic                  lane_done,
  input  logic [WORD_W-1:0]     lane_result,
  output logic                  busy,
  output logic                  done,
  output logic [WORD_W-1:0]     raw_flags,
  output logic [WORD_W-1:0]     dma_flags,
  output logic [WORD_W-1:0]     bytes_left
);

  localparam logic [WORD_W-1:0] STEP    = WORD_W'(WORD_BYTES);
  localparam logic [WORD_W-1:0] OWN_CLR = ~(WORD_W'(1) << DESC_OWN_BIT);

  wk_state_e             state;
  logic                  dir_q;
  logic [WORD_W-1:0]     rem_q;
  logic [WORD_W-1:0]     daddr;
  logic [WORD_W-1:0]     st_word;
  logic [WORD_W-1:0]     size_raw;
  logic [WORD_W-1:0]     buf_base;
  logic [WORD_W-1:0]     nxt;
  logic [WORD_W-1:0]     chunk_q;
  logic [WORD_W-1:0]     offs;
  logic [IDX_W-1:0]      nb_q;
  logic [WORD_W-1:0]     chunk_c;
  logic [WORD_W-1:0]     seg_left;
  logic [IDX_W-1:0]      seg_nb;
  logic [WORD_W-1:0]     offs_nxt;
  logic                  seg_last;
  logic [WORD_W-1:0]     rem_after;
  logic [WORD_BYTES-1:0] be_mask;
  logic                  accept;

  sdma_chunk_calc #(
    .WORD_W        (WORD_W),
    .MAX_DESC_BYTES(MAX_DESC_BYTES)
  ) u_chunk (
    .size_raw (size_raw),
    .remaining(rem_q),
    .chunk    (chunk_c)
  );

  assign accept   = start && dma_en && (byte_count != '0) && (block_size != '0) &&
                    (dir_tx || card_ready);
  assign seg_left = chunk_q - offs;
  assign seg_nb   = (seg_left >= STEP) ? IDX_W'(WORD_BYTES) : IDX_W'(seg_left);
  assign offs_nxt = offs + WORD_W'(nb_q);
  assign seg_last = (offs_nxt == chunk_q);
  assign rem_after = (rem_q > chunk_q) ? (rem_q - chunk_q) : '0;

  always_comb begin
    for (int i = 0; i < WORD_BYTES; i++) begin
      be_mask[i] = (i < int'(nb_q));
    end
  end

  assign busy       = (state != WK_IDLE);
  assign bytes_left = rem_q;
  assign lane_dir   = dir_q;
  assign lane_nbytes = nb_q;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = daddr;
    mem_wdata = '0;
    mem_be    = '1;
    case (state)
      WK_STAT: mem_req = 1'b1;
      WK_SIZE: begin mem_req = 1'b1; mem_addr = daddr + STEP;        end
      WK_BUF:  begin mem_req = 1'b1; mem_addr = daddr + (STEP << 1); end
      WK_NEXT: begin mem_req = 1'b1; mem_addr = daddr + STEP * 3;    end
      WK_MRD:  begin mem_req = 1'b1; mem_addr = buf_base + offs;     end
      WK_MWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_base + offs;
        mem_wdata = lane_result;
        mem_be    = be_mask;
      end
      WK_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = st_word & OWN_CLR;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= WK_IDLE;
      dir_q     <= 1'b0;
      rem_q     <= '0;
      daddr     <= '0;
      st_word   <= '0;
      size_raw  <= '0;
      buf_base  <= '0;
      nxt       <= '0;
      chunk_q   <= '0;
      offs      <= '0;
      nb_q      <= '0;
      lane_go   <= 1'b0;
      lane_word <= '0;
      done      <= 1'b0;
      raw_flags <= '0;
      dma_flags <= '0;
    end else begin
      lane_go <= 1'b0;
      done    <= 1'b0;
      case (state)
        WK_IDLE: if (accept) begin
          dir_q     <= dir_tx;
          rem_q     <= byte_count;
          daddr     <= desc_base;
          raw_flags <= '0;
          dma_flags <= '0;
          state     <= WK_STAT;
        end
        WK_STAT: if (mem_ack) begin
          st_word <= mem_rdata;
          state   <= WK_SIZE;
        end
        WK_SIZE: if (mem_ack) begin
          size_raw <= mem_rdata;
          state    <= WK_BUF;
        end
        WK_BUF: if (mem_ack) begin
          buf_base <= {mem_rdata[WORD_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
          state    <= WK_NEXT;
        end
        WK_NEXT: if (mem_ack) begin
          nxt     <= mem_rdata;
          chunk_q <= chunk_c;
          offs    <= '0;
          state   <= WK_SEG;
        end
        WK_SEG: begin
          nb_q <= seg_nb;
          if (dir_q) begin
            state <= WK_MRD;
          end else begin
            lane_go   <= 1'b1;
            lane_word <= '0;
            state     <= WK_LANE;
          end
        end
        WK_MRD: if (mem_ack) begin
          lane_word <= mem_rdata;
          lane_go   <= 1'b1;
          state     <= WK_LANE;
        end
        WK_LANE: if (lane_done) begin
          if (dir_q) begin
            offs  <= offs_nxt;
            state <= seg_last ? WK_WB : WK_SEG;
          end else begin
            state <= WK_MWR;
          end
        end
        WK_MWR: if (mem_ack) begin
          offs  <= offs_nxt;
          state <= seg_last ? WK_WB : WK_SEG;
        end
        WK_WB: if (mem_ack) begin
          rem_q <= rem_after;
          if (st_word[DESC_LAST_BIT] || (rem_after == '0)) begin
            state <= WK_FIN;
          end else begin
            daddr <= nxt;
            state <= WK_STAT;
          end
        end
        WK_FIN: begin
          done                   <= 1'b1;
          raw_flags[RAW_XFER_DONE] <= 1'b1;
          raw_flags[RAW_DMA_EVENT] <= 1'b1;
          dma_flags[DMA_SUMMARY]   <= 1'b1;
          dma_flags[DMA_TX_DONE]   <= dir_q;
          dma_flags[DMA_RX_DONE]   <= ~dir_q;
          state                  <= WK_IDLE;
        end
        default: state <= WK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdma_chain_engine.sv
module sdma_chain_engine #(
  parameter int WORD_W         = 32,
  parameter int BYTE_W         = 8,
  parameter int MAX_DESC_BYTES = 8192
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       dma_en,
  input  logic                       dir_tx,
  input  logic [WORD_W-1:0]          byte_count,
  input  logic [WORD_W-1:0]          block_size,
  input  logic [WORD_W-1:0]          desc_base,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [WORD_W-1:0]          mem_addr,
  output logic [WORD_W-1:0]          mem_wdata,
  output logic [WORD_W/BYTE_W-1:0]   mem_be,
  input  logic                       mem_ack,
  input  logic [WORD_W-1:0]          mem_rdata,
  output logic                       card_tx_valid,
  output logic [BYTE_W-1:0]          card_tx_data,
  input  logic                       card_tx_ready,
  input  logic                       card_rx_valid,
  input  logic [BYTE_W-1:0]          card_rx_data,
  output logic                       card_rx_ready,
  output logic                       busy,
  output logic                       done,
  output logic [WORD_W-1:0]          raw_flags,
  output logic [WORD_W-1:0]          dma_flags,
  output logic [WORD_W-1:0]          bytes_left
);

  localparam int WORD_BYTES = WORD_W / BYTE_W;
  localparam int IDX_W      = $clog2(WORD_BYTES + 1);

  logic              lane_go;
  logic              lane_dir;
  logic [WORD_W-1:0] lane_word;
  logic [IDX_W-1:0]  lane_nbytes;
  logic              lane_done;
  logic [WORD_W-1:0] lane_result;

  sdma_walker #(
    .WORD_W        (WORD_W),
    .BYTE_W        (BYTE_W),
    .MAX_DESC_BYTES(MAX_DESC_BYTES)
  ) u_walker (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .dma_en     (dma_en),
    .dir_tx     (dir_tx),
    .byte_count (byte_count),
    .block_size (block_size),
    .desc_base  (desc_base),
    .card_ready (card_rx_valid),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_be     (mem_be),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .lane_go    (lane_go),
    .lane_dir   (lane_dir),
    .lane_word  (lane_word),
    .lane_nbytes(lane_nbytes),
    .lane_done  (lane_done),
    .lane_result(lane_result),
    .busy       (busy),
    .done       (done),
    .raw_flags  (raw_flags),
    .dma_flags  (dma_flags),
    .bytes_left (bytes_left)
  );

  sdma_byte_lane #(
    .WORD_W(WORD_W),
    .BYTE_W(BYTE_W)
  ) u_lane (
    .clk     (clk),
    .rst     (rst),
    .go      (lane_go),
    .dir_tx  (lane_dir),
    .word_in (lane_word),
    .nbytes  (lane_nbytes),
    .tx_valid(card_tx_valid),
    .tx_data (card_tx_data),
    .tx_ready(card_tx_ready),
    .rx_valid(card_rx_valid),
    .rx_data (card_rx_data),
    .rx_ready(card_rx_ready),
    .word_out(lane_result),
    .done    (lane_done)
  );

endmodule

// File: rtl/sdma_chain_engine_chk.sv
module sdma_chain_engine_chk #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_addr,
  input logic              card_tx_valid,
  input logic [BYTE_W-1:0] card_tx_data,
  input logic              card_tx_ready,
  input logic              card_rx_ready,
  input logic [WORD_W-1:0] raw_flags,
  input logic [WORD_W-1:0] dma_flags,
  input logic [WORD_W-1:0] bytes_left
);

  AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10

  AST_TX_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
    card_tx_valid && !card_tx_ready |=> card_tx_valid && $stable(card_tx_data)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req && !card_tx_valid && !card_rx_ready); // R1

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
    !(card_tx_valid && card_rx_ready)); // R2

  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    done |-> raw_flags[3] && raw_flags[16] && dma_flags[8] &&
             ($countones(dma_flags[1:0]) == 1)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_LEFT_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> bytes_left <= $past(bytes_left)); // R8

endmodule

bind sdma_chain_engine sdma_chain_engine_chk #(
  .WORD_W(WORD_W),
  .BYTE_W(BYTE_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .done         (done),
  .mem_req      (mem_req),
  .mem_ack      (mem_ack),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .card_tx_valid(card_tx_valid),
  .card_tx_data (card_tx_data),
  .card_tx_ready(card_tx_ready),
  .card_rx_ready(card_rx_ready),
  .raw_flags    (raw_flags),
  .dma_flags    (dma_flags),
  .bytes_left   (bytes_left)
);

// File: tb/sdma_chain_engine_tb.sv
`timescale 1ns/1ps
module sdma_chain_engine_tb;

  localparam int MAXD = 16;
  localparam int MW   = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, dma_en = 1'b0, dir_tx = 1'b0;
  logic [31:0] byte_count = '0, block_size = '0, desc_base = '0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        card_tx_valid, card_tx_ready, card_rx_valid, card_rx_ready;
  logic [7:0]  card_tx_data, card_rx_data;
  logic        busy, done;
  logic [31:0] raw_flags, dma_flags, bytes_left;

  always #10 clk = ~clk;

  sdma_chain_engine #(.MAX_DESC_BYTES(MAXD)) u_dut (
    .clk(clk), .rst(rst), .start(start), .dma_en(dma_en), .dir_tx(dir_tx),
    .byte_count(byte_count), .block_size(block_size), .desc_base(desc_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .card_tx_valid(card_tx_valid), .card_tx_data(card_tx_data),
    .card_tx_ready(card_tx_ready), .card_rx_valid(card_rx_valid),
    .card_rx_data(card_rx_data), .card_rx_ready(card_rx_ready),
    .busy(busy), .done(done), .raw_flags(raw_flags), .dma_flags(dma_flags),
    .bytes_left(bytes_left));

  int n_tests = 0, n_fail = 0;
  int cyc = 0, rx_cnt = 0, req_cnt = 0;
  bit stall = 1'b0, rx_en = 1'b1;

  logic [31:0] mem     [MW];
  logic [31:0] fill_v  [MW];
  logic        fill_go = 1'b0;
  logic [31:0] snap    [MW];
  logic [31:0] exp_mem [MW];
  byte unsigned got_q[$];
  byte unsigned exp_q[$];
  int exp_left;

  function automatic logic [7:0] rx_byte(int k);
    return 8'((k * 7 + 3) & 255);
  endfunction

  assign card_rx_data = rx_byte(rx_cnt);

  // Memory, card sink and card source models.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fill_go) begin
      for (int i = 0; i < MW; i++) mem[i] <= fill_v[i];
    end
    if (rst) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack && (!stall || (cyc % 4 != 3))) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[10:2]];
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[10:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end
    end else begin
      mem_ack <= 1'b0;
    end
    if (mem_req) req_cnt <= req_cnt + 1;
    card_tx_ready <= !rst && (!stall || (cyc % 3 != 1));
    card_rx_valid <= !rst && rx_en && (!stall || (cyc % 5 != 2));
    if (card_tx_valid && card_tx_ready) got_q.push_back(card_tx_data);
    if (card_rx_valid && card_rx_ready) rx_cnt <= rx_cnt + 1;
  end

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic load_mem();
    fill_go = 1'b1;
    @(negedge clk);
    fill_go = 1'b0;
    @(negedge clk);
  endtask

  task automatic background(int seed);
    for (int i = 0; i < MW; i++) fill_v[i] = (i * 32'h0101_0107) ^ (seed * 32'h9E37_79B1);
  endtask

  task automatic put_desc(int a, logic [31:0] st, logic [31:0] sz, logic [31:0] ba,
                          logic [31:0] nx);
    fill_v[a/4] = st; fill_v[a/4+1] = sz; fill_v[a/4+2] = ba; fill_v[a/4+3] = nx;
  endtask

  // Independent walk of the descriptor chain following R2..R8.
  task automatic model(bit tx, int base, int count, int rx0);
    int a = base, rem = count, k = 0;
    for (int i = 0; i < MW; i++) exp_mem[i] = snap[i];
    exp_q.delete();
    forever begin
      logic [31:0] st, sz, ba, nx;
      int eff, n;
      st = snap[a/4]; sz = snap[a/4+1]; ba = snap[a/4+2] & 32'hFFFF_FFFC; nx = snap[a/4+3];
      eff = (sz == 0 || sz > MAXD) ? MAXD : int'(sz);
      n   = (eff < rem) ? eff : rem;
      for (int i = 0; i < n; i++) begin
        int ad = int'(ba) + i;
        if (tx) exp_q.push_back(snap[ad/4][8*(ad%4) +: 8]);
        else begin
          exp_mem[ad/4][8*(ad%4) +: 8] = rx_byte(rx0 + k);
          k++;
        end
      end
      exp_mem[a/4] = st & 32'h7FFF_FFFF;
      rem -= n;
      if (st[2] || rem == 0) break;
      a = int'(nx);
    end
    exp_left = rem;
  endtask

  task automatic run(bit tx, int base, int count, bit stl, string tag);
    int bad;
    bit seen = 1'b0;
    stall = stl;
    for (int i = 0; i < MW; i++) snap[i] = mem[i];
    model(tx, base, count, rx_cnt);
    got_q.delete();
    dma_en = 1'b1; dir_tx = tx; byte_count = count; block_size = 32'd512;
    desc_base = base;
    if (!tx) begin
      do @(negedge clk); while (!card_rx_valid);
    end else @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && raw_flags == 0 && dma_flags == 0, "R9", {tag, " flags cleared at start"},
        {busy, raw_flags}, 1);
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(seen, "R9", {tag, " done pulse"}, seen, 1);
    @(negedge clk);
    chk(raw_flags == 32'h0001_0008, "R9", {tag, " raw flags"}, raw_flags, 32'h0001_0008);
    chk(dma_flags == (tx ? 32'h101 : 32'h102), "R9", {tag, " dma flags"}, dma_flags,
        tx ? 32'h101 : 32'h102);
    chk(bytes_left == exp_left, "R8", {tag, " bytes left"}, bytes_left, exp_left);
    if (tx) begin
      bad = (got_q.size() != exp_q.size()) ? 1 : 0;
      for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
        if (got_q[i] != exp_q[i]) bad++;
      chk(bad == 0, "R5", {tag, " card byte stream"}, got_q.size(), exp_q.size());
    end
    bad = 0;
    for (int i = 0; i < MW; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, tx ? "R7" : "R6", {tag, " memory image"}, bad, 0);
    stall = 1'b0;
  endtask

  task automatic try_reject(bit en, int cnt, int bsz, bit tx, string what);
    int r0, rx0;
    dma_en = en; byte_count = cnt; block_size = bsz; dir_tx = tx; desc_base = 0;
    @(negedge clk);
    r0 = req_cnt; rx0 = rx_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk(!busy && req_cnt == r0 && rx_cnt == rx0 && got_q.size() == 0 && !done,
        "R1", what, req_cnt - r0, 0);
  endtask

  initial begin
    #(20 * 190000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    background(1);
    put_desc(0, 32'h8000_0004, 32'd8, 32'h100, 32'h0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    load_mem();
    // R11 reset state
    chk(!busy && !done && !mem_req && !card_tx_valid && !card_rx_ready, "R11",
        "idle outputs after reset", {busy, done, mem_req}, 0);
    chk(raw_flags == 0 && dma_flags == 0 && bytes_left == 0, "R11", "flags after reset",
        raw_flags | dma_flags | bytes_left, 0);

    // R1 rejected starts
    got_q.delete();
    try_reject(1'b0, 8, 512, 1'b1, "start with DMA disabled");
    try_reject(1'b1, 0, 512, 1'b1, "start with zero byte count");
    try_reject(1'b1, 8, 0, 1'b1, "start with zero block size");
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    try_reject(1'b1, 8, 512, 1'b0, "card-to-memory start without card data");
    rx_en = 1'b1;

    // R2 R4 R5 R7: single memory-to-card descriptor
    background(2);
    put_desc(0, 32'hC000_000C, 32'd10, 32'h100, 32'h0);
    load_mem();
    run(1'b1, 0, 10, 1'b0, "R2 single tx");

    // R3 R8: chain with zero size, oversized entry and last flag
    background(3);
    put_desc(32'h000, 32'h8000_0018, 32'd0,  32'h100, 32'h040);
    put_desc(32'h040, 32'h8000_0010, 32'd40, 32'h200, 32'h080);
    put_desc(32'h080, 32'h8000_0014, 32'd5,  32'h300, 32'h0C0);
    put_desc(32'h0C0, 32'h8000_0014, 32'd9,  32'h380, 32'h000);
    load_mem();
    run(1'b1, 0, 100, 1'b1, "R3 clamp chain tx");

    // R8: byte count runs out before any last flag; third descriptor untouched
    background(4);
    put_desc(32'h000, 32'h8000_0010, 32'd8, 32'h100, 32'h040);
    put_desc(32'h040, 32'h8000_0010, 32'd8, 32'h200, 32'h080);
    put_desc(32'h080, 32'h8000_0010, 32'd8, 32'h300, 32'h000);
    load_mem();
    run(1'b1, 0, 13, 1'b1, "R8 count cutoff tx");

    // R4 R6: card-to-memory, unaligned buffer address, stalls
    background(5);
    put_desc(32'h000, 32'h8000_0004, 32'd11, 32'h203, 32'h000);
    load_mem();
    run(1'b0, 0, 11, 1'b1, "R4 unaligned rx");

    // R3 R6: card-to-memory chain, zero size first entry
    background(6);
    put_desc(32'h000, 32'h8000_0010, 32'd0,  32'h100, 32'h060);
    put_desc(32'h060, 32'h8000_0014, 32'd30, 32'h200, 32'h000);
    load_mem();
    run(1'b0, 0, 20, 1'b0, "R3 chain rx");

    // R4 R5 R6: sweep of size and count on one descriptor, both directions
    for (int d = 0; d < 2; d++) begin
      for (int sz = 1; sz <= 9; sz++) begin
        for (int cnt = 1; cnt <= 9; cnt++) begin
          background(sz * 16 + cnt + d);
          put_desc(32'h000, 32'h8000_0004, sz, 32'h100 + cnt % 4, 32'h000);
          load_mem();
          run(d[0], 0, cnt, ((sz + cnt) % 2) == 1, d ? "R5 sweep tx" : "R6 sweep rx");
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule